// File: doc/BRIEF.md
# Interleaved Converter Output Multiplexer and Formatter

This block sits at the back end of a time-interleaved converter built from sixteen parallel slices. Every clock cycle exactly one slice hands over an 11-bit raw result. The block picks that slice with a round-robin pointer and turns the raw value into a 10-bit straight-binary code plus an overrange flag. It registers the word on the rising clock edge and delays it so that each code leaves the block a fixed number of cycles after its sample was taken.

A data-valid flag tells downstream logic when the first real result has reached the output. An active-low enable drives one output-enable line per bus bit, so a pad ring can place the eleven bus bits in high impedance. The slices themselves, and their calibration, live outside this block.

In the text below, cycle 0 is the first clock cycle in which reset is low. Sample n is taken in cycle n by slice (n mod 16). Its raw result is presented on that slice's lane during cycle n+11.

Top module: `imf_output_mux`

## Requirements
- R1: In cycle n (n ≥ 11) the block takes the lane of slice ((n − 11) mod 16), so each of the 16 lanes is read exactly once every 16 cycles. Lane k occupies bits [11k+10 : 11k] of the lane bus.
- R2: A raw result below 1024 appears as code_o equal to its low ten bits (bit 0 is the LSB), with ovr_o at 0.
- R3: A raw result of 1024 or more sets ovr_o to 1 and forces all ten bits of code_o to 1 (0x3FF).
- R4: Outputs change only at a rising clock edge. A change on the lane bus between edges does not alter code_o, ovr_o or dvalid_o.
- R5: The code for sample n is visible during cycle n+12, a fixed latency of 12 cycles.
- R6: dvalid_o is 0 from reset through cycle 11 and goes to 1 in cycle 12, when the first result reaches the output. It then stays at 1 until the next reset.
- R7: When oe_n_i is 1, all eleven bits of bus_oe_o are 0, and when it is 0 they are all 1, with no clock delay. oe_n_i has no effect on code_o, ovr_o or dvalid_o.
- R8: A synchronous, active-high rst clears code_o, ovr_o and dvalid_o at the next rising edge. While dvalid_o is 0, code_o and ovr_o stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lanes_i | input | 176 | Raw 11-bit results of the 16 slices, lane k at bits [11k+10:11k] |
| oe_n_i | input | 1 | Active-low bus output enable |
| code_o | output | 10 | Straight-binary output code, bit 0 the LSB |
| ovr_o | output | 1 | Overrange flag |
| dvalid_o | output | 1 | High once the first real result has reached the output |
| bus_oe_o | output | 11 | Per-bit output enable for {ovr_o, code_o}, high means driven |

## Verification
The hardest thing to show from the ports is that the right lane is read in the right cycle. All lanes hold data at once, so a wrong pointer phase shows up only when every lane holds a value that differs from all the others. The stimulus therefore runs a phase in which each lane's value encodes its own index and changes every cycle. Each output code then identifies both the slice and the cycle it came from.

A reset in the middle of the run checks that the phase restarts and that dvalid_o waits its full twelve cycles again. Lane values are also inverted between edges to show that only the edge-sampled value is used.

// File: rtl/imf_pkg.sv
package imf_pkg;

    localparam int RAW_W  = 11;
    localparam int CODE_W = RAW_W - 1;
    localparam int BUS_W  = CODE_W + 1;

    typedef struct packed {
        logic              vld;
        logic              ovr;
        logic [CODE_W-1:0] code;
    } out_word_t;

    function automatic out_word_t fmt_raw(input logic [RAW_W-1:0] raw);
        out_word_t w;
        w.vld = 1'b1;
        if (raw[RAW_W-1]) begin
            w.ovr  = 1'b1;
            w.code = '1;
        end else begin
            w.ovr  = 1'b0;
            w.code = raw[CODE_W-1:0];
        end
        return w;
    endfunction

endpackage

// File: rtl/imf_phase_seq.sv
module imf_phase_seq #(
    parameter int NUM_SLICES = 16,
    parameter int CONV_CYC   = 11,
    localparam int SEL_W     = $clog2(NUM_SLICES),
    localparam int CNT_W     = $clog2(CONV_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SEL_W-1:0] sel_o,
    output logic             live_o
);
    localparam logic [SEL_W-1:0] LAST_SEL  = SEL_W'(NUM_SLICES - 1);
    localparam logic [SEL_W-1:0] START_SEL =
        SEL_W'((NUM_SLICES - (CONV_CYC % NUM_SLICES)) % NUM_SLICES);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(CONV_CYC);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= START_SEL;
            cnt_q <= '0;
        end else begin
            sel_q <= (sel_q == LAST_SEL) ? '0 : sel_q + 1'b1;
            if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sel_o  = sel_q;
    assign live_o = (cnt_q == CNT_TOP);

    // R1: the pointer visits the slices in strict ascending order
    assert_rr_step_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_q != LAST_SEL) |=> (sel_q == $past(sel_q) + 1'b1));
    assert_rr_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_q == LAST_SEL) |=> (sel_q == '0));

endmodule

// File: rtl/imf_slice_mux.sv
module imf_slice_mux
    import imf_pkg::*;
#(
    parameter int NUM_SLICES = 16,
    localparam int SEL_W     = $clog2(NUM_SLICES)
) (
    input  logic [NUM_SLICES*RAW_W-1:0] lanes_i,
    input  logic [SEL_W-1:0]            sel_i,
    output out_word_t                   word_o
);
    logic [RAW_W-1:0] lane_arr [NUM_SLICES];

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_lane
        assign lane_arr[k] = lanes_i[k*RAW_W +: RAW_W];
    end

    assign word_o = fmt_raw(lane_arr[sel_i]);

endmodule

// File: rtl/imf_out_stage.sv
module imf_out_stage
    import imf_pkg::*;
#(
    parameter int PAD = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      live_i,
    input  out_word_t word_i,
    output out_word_t word_o
);
    out_word_t pipe_q [PAD+1];

    always_ff @(posedge clk) begin
        if (rst)         pipe_q[0] <= '0;
        else if (live_i) pipe_q[0] <= word_i;
    end

    for (genvar g = 1; g <= PAD; g++) begin : g_pad
        always_ff @(posedge clk) begin
            if (rst) pipe_q[g] <= '0;
            else     pipe_q[g] <= pipe_q[g-1];
        end
    end

    assign word_o = pipe_q[PAD];

    // R3: a raised overrange flag always leaves with a saturated code
    assert_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        word_o.ovr |-> (word_o.code == '1));
    // R6: once valid, the output stays valid
    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        word_o.vld |=> word_o.vld);

endmodule

// File: rtl/imf_output_mux.sv
module imf_output_mux
    import imf_pkg::*;
#(
    parameter int NUM_SLICES = 16,
    parameter int CONV_CYC   = 11,
    parameter int LATENCY    = 12,
    localparam int SEL_W     = $clog2(NUM_SLICES),
    localparam int PAD       = LATENCY - CONV_CYC - 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SLICES*RAW_W-1:0] lanes_i,
    input  logic                        oe_n_i,
    output logic [CODE_W-1:0]           code_o,
    output logic                        ovr_o,
    output logic                        dvalid_o,
    output logic [BUS_W-1:0]            bus_oe_o
);
    logic [SEL_W-1:0] sel;
    logic             live;
    out_word_t        mux_word;
    out_word_t        out_word;

    imf_phase_seq #(.NUM_SLICES(NUM_SLICES), .CONV_CYC(CONV_CYC)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .sel_o  (sel),
        .live_o (live)
    );

    imf_slice_mux #(.NUM_SLICES(NUM_SLICES)) u_mux (
        .lanes_i (lanes_i),
        .sel_i   (sel),
        .word_o  (mux_word)
    );

    imf_out_stage #(.PAD(PAD)) u_out (
        .clk    (clk),
        .rst    (rst),
        .live_i (live),
        .word_i (mux_word),
        .word_o (out_word)
    );

    assign code_o   = out_word.code;
    assign ovr_o    = out_word.ovr;
    assign dvalid_o = out_word.vld;
    assign bus_oe_o = {BUS_W{~oe_n_i}};

    // R8: nothing but zeros leaves the block before the first real result
    assert_quiet_before_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !dvalid_o |-> (code_o == '0 && !ovr_o));
    // R6: valid appears only after the sequencer reports a live transfer
    assert_valid_after_live_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dvalid_o) |-> $past(live));

endmodule

// File: tb/imf_output_mux_test.sv
module imf_output_mux_test;

    localparam int NS   = 16;
    localparam int RW   = 11;
    localparam int CONV = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NS*RW-1:0] lanes = '0;
    logic             oe_n = 1'b0;
    logic [9:0]       code_o;
    logic             ovr_o;
    logic             dvalid_o;
    logic [10:0]      bus_oe_o;

    int checks = 0;
    int failures = 0;
    int n = 0;
    int nn = 0;
    int mode = 0;
    bit finished = 0;

    logic       exp_v = 1'b0, exp_o = 1'b0, prev_v = 1'b0, last_rst = 1'b1;
    logic [9:0] exp_c = '0;

    imf_output_mux uut (
        .clk(clk), .rst(rst), .lanes_i(lanes), .oe_n_i(oe_n),
        .code_o(code_o), .ovr_o(ovr_o), .dvalid_o(dvalid_o), .bus_oe_o(bus_oe_o)
    );

    always #5 clk = ~clk;

    // reference model: expected output word after each edge
    always @(posedge clk) begin
        last_rst = rst;
        if (rst) begin
            n = 0; exp_v = 0; exp_o = 0; exp_c = '0;
        end else begin
            if (n >= CONV) begin
                int lane_v;
                lane_v = int'(lanes[((n - CONV) % NS)*RW +: RW]);
                exp_v = 1;
                if (lane_v >= 1024) begin exp_o = 1; exp_c = 10'h3FF; end
                else begin exp_o = 0; exp_c = lane_v[9:0]; end
            end
            n = n + 1;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int lane_val(input int m, input int k, input int t);
        case (m)
            0: return (t * 37 + k * 101 + 5) % 2048;
            1: return (k % 2 == 0) ? 1023 : 1024;
            2: return k * 64 + (t % 64);       // R1: value names its lane
            default: return ((k + t) % 2 == 0) ? 2047 : 0;
        endcase
    endfunction

    task automatic drive_lanes();
        for (int k = 0; k < NS; k++) lanes[k*RW +: RW] = RW'(lane_val(mode, k, nn));
    endtask

    task automatic compare();
        string tag;
        if (last_rst) tag = "R8";
        else if (exp_v && !prev_v) tag = "R5";
        else if (mode == 2) tag = "R1";
        else if (exp_o) tag = "R3";
        else tag = "R2";
        check(last_rst ? "R8" : "R6", "dvalid", int'(dvalid_o), int'(exp_v));
        check(tag, "ovr", int'(ovr_o), int'(exp_o));
        check(tag, "code", int'(code_o), int'(exp_c));
        prev_v = exp_v;
    endtask

    initial begin
        drive_lanes();
        repeat (3) @(negedge clk);
        compare();                         // R8 reset state
        check("R7", "bus_oe", int'(bus_oe_o), 2047);
        rst = 0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            compare();
            nn++;
            mode = (cyc < 100) ? 0 : (cyc < 180) ? 2 : (cyc < 260) ? 1 : (cyc < 330) ? 3 : 2;
            if (cyc % 25 == 7) begin       // R4: lanes flip between edges
                logic [9:0] c0; logic o0, v0;
                c0 = code_o; o0 = ovr_o; v0 = dvalid_o;
                lanes = ~lanes;
                #1;
                check("R4", "code held", int'(code_o), int'(c0));
                check("R4", "ovr held", int'(ovr_o), int'(o0));
                check("R4", "valid held", int'(dvalid_o), int'(v0));
            end
            if (cyc == 60 || cyc == 290) begin   // R7: tri-state request
                oe_n = 1; #1;
                check("R7", "bus_oe off", int'(bus_oe_o), 0);
                check("R7", "valid unaffected", int'(dvalid_o), int'(exp_v));
            end
            if (cyc == 75 || cyc == 300) begin
                oe_n = 0; #1;
                check("R7", "bus_oe on", int'(bus_oe_o), 2047);
            end
            rst = (cyc == 200 || cyc == 201);    // R8 / R6 restart
            drive_lanes();
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule